// File: doc/BRIEF.md
# Chainable Dual Down-Counter Timer

A set of identical down-counting timers (two by default, 32 bits wide) behind a small write-strobe register bus. Each timer holds a reload value and a control word with a run bit, an auto-reload bit and a one-shot load strobe. It drives a level interrupt that rises when the count reaches zero. The interrupt falls only when the count is reloaded, either by the automatic reload or by software writing the load strobe. Reading a register never clears it.

Every timer after the first can be chained to its lower neighbour. In that mode it advances once for each expiry of the lower timer, so the two together give a period equal to the product of their individual periods. All timers share one clock-enable input, `tick_en`, which is the only prescaling. The current count of any timer can be read at any time. A read has no effect on counting.

Top module: `dual_down_timer`

## Requirements
- R1: While a timer's run bit is 1 and its count is nonzero, each cycle with an active step (`tick_en`=1, or a lower-timer expiry when chained) lowers the count by exactly one.
- R2: With the run bit 0, or on a cycle without a step, the count keeps its value.
- R3: Writing control with bit 2 (load) set makes the count equal the reload value on the next cycle, whether the timer runs or not. Writing the reload register alone leaves the count unchanged.
- R4: The interrupt rises in the same cycle in which counting brings the count to zero.
- R5: With auto-reload (control bit 1) set, a step taken at zero reloads the count and drops the interrupt. The interrupt period is (reload+1) steps.
- R6: With auto-reload clear, the count stays at zero and the interrupt stays high until a load strobe, which clears it.
- R7: Register reads (`bus_sel`=1, `bus_wr`=0) change neither counts nor interrupts.
- R8: Control bit 3 (chain) on timer k>0 makes it step only on cycles where timer k-1 runs, has a step and sits at zero. The combined interrupt period is (R0+1)(R1+1) ticks. On timer 0 this bit is ignored and reads 0.
- R9: The address is {timer index, 2-bit register}. Register 0 is the reload value (read/write). Register 1 is control: bit0 run, bit1 auto-reload, bit2 load (write-only, reads 0), bit3 chain. Register 2 is the count (read-only; writes are ignored). Register 3 reads 0.
- R10: After reset all counts, reload values, control bits and interrupts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Shared count enable (prescaler output) |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_addr | input | AW (3) | {timer index, register} |
| bus_wdata | input | WIDTH (32) | Write data |
| bus_rdata | output | WIDTH (32) | Combinational read data for bus_addr |
| irq_o | output | N_TIMERS (2) | Level interrupt per timer |

## Verification
A wrong count appears on the count register readback in the cycle after the faulty update. A misplaced set or clear of the interrupt state appears on `irq_o` in the same cycle. The bench keeps a behavioural model, reads a register every cycle and compares it with the model, so a divergence is reported within one clock. Chaining faults show up only once timer 0 expires, so the chain periods are also measured rise-to-rise on the interrupt.

// File: rtl/dtimer_pkg.sv
package dtimer_pkg;
    localparam int REG_RELOAD = 0;
    localparam int REG_CTRL   = 1;
    localparam int REG_COUNT  = 2;

    localparam int BIT_RUN  = 0;
    localparam int BIT_AUTO = 1;
    localparam int BIT_LOAD = 2;
    localparam int BIT_CHAIN = 3;

    typedef struct packed {
        logic chain;
        logic auto_rl;
        logic run;
    } tmr_ctrl_t;
endpackage

// File: rtl/dtimer_core.sv
module dtimer_core #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             run_i,
    input  logic             auto_i,
    input  logic             step_i,
    input  logic [WIDTH-1:0] reload_i,
    output logic [WIDTH-1:0] count_o,
    output logic             irq_o,
    output logic             expire_o
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    typedef struct packed {
        logic [WIDTH-1:0] count;
        logic             irq;
    } core_t;

    core_t state_d, state_q;
    logic  at_zero;

    always_comb begin
        state_d  = state_q;
        at_zero  = (state_q.count == '0);
        expire_o = run_i && step_i && at_zero;
        if (load_i) begin
            state_d.count = reload_i;
            state_d.irq   = 1'b0;
        end else if (run_i && step_i) begin
            if (at_zero) begin
                if (auto_i) begin
                    state_d.count = reload_i;
                    state_d.irq   = 1'b0;
                end
            end else begin
                state_d.count = state_q.count - ONE;
                if (state_q.count == ONE) begin
                    state_d.irq = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign count_o = state_q.count;
    assign irq_o   = state_q.irq;

    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && run_i && step_i && count_o != '0) |=> (count_o == $past(count_o) - ONE)); // R1
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !(run_i && step_i)) |=> $stable(count_o)); // R2
    AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (count_o == $past(reload_i) && !irq_o)); // R3
    AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> (count_o == '0)); // R4
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !load_i && !(run_i && step_i && auto_i)) |=> irq_o); // R6
endmodule

// File: rtl/dtimer_regs.sv
module dtimer_regs
    import dtimer_pkg::*;
#(
    parameter int N     = 2,
    parameter int WIDTH = 32,
    parameter int IDX_W = 1,
    parameter int AW    = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_sel,
    input  logic                        bus_wr,
    input  logic [AW-1:0]               bus_addr,
    input  logic [WIDTH-1:0]            bus_wdata,
    input  logic [N-1:0][WIDTH-1:0]     count_i,
    output logic [WIDTH-1:0]            bus_rdata,
    output logic [N-1:0][WIDTH-1:0]     reload_o,
    output tmr_ctrl_t [N-1:0]           ctrl_o,
    output logic [N-1:0]                load_o
);
    typedef struct packed {
        logic [N-1:0][WIDTH-1:0] rl;
        tmr_ctrl_t [N-1:0]       ctl;
    } regs_t;

    regs_t       regs_d, regs_q;
    logic [IDX_W-1:0] idx;
    logic [1:0]  reg_sel;
    logic        in_range;
    logic        wr_en;

    assign idx      = bus_addr[AW-1:2];
    assign reg_sel  = bus_addr[1:0];
    assign in_range = (32'(idx) < N);
    assign wr_en    = bus_sel && bus_wr && in_range;

    always_comb begin
        regs_d = regs_q;
        load_o = '0;
        for (int k = 0; k < N; k++) begin
            if (wr_en && idx == IDX_W'(k)) begin
                if (reg_sel == 2'(REG_RELOAD)) begin
                    regs_d.rl[k] = bus_wdata;
                end
                if (reg_sel == 2'(REG_CTRL)) begin
                    regs_d.ctl[k].run     = bus_wdata[BIT_RUN];
                    regs_d.ctl[k].auto_rl = bus_wdata[BIT_AUTO];
                    regs_d.ctl[k].chain   = (k > 0) && bus_wdata[BIT_CHAIN];
                    load_o[k]             = bus_wdata[BIT_LOAD];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (in_range) begin
            case (reg_sel)
                2'(REG_RELOAD): bus_rdata = regs_q.rl[idx];
                2'(REG_CTRL):   bus_rdata = {{(WIDTH-4){1'b0}}, regs_q.ctl[idx].chain, 1'b0,
                                             regs_q.ctl[idx].auto_rl, regs_q.ctl[idx].run};
                2'(REG_COUNT):  bus_rdata = count_i[idx];
                default:        bus_rdata = '0;
            endcase
        end
    end

    assign reload_o = regs_q.rl;
    assign ctrl_o   = regs_q.ctl;

    AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load_o)); // R9
    AST_RELOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr) |=> $stable(reload_o)); // R3
    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr) |=> $stable(ctrl_o)); // R7
endmodule

// File: rtl/dual_down_timer.sv
module dual_down_timer
    import dtimer_pkg::*;
#(
    parameter int N_TIMERS = 2,
    parameter int WIDTH    = 32,
    localparam int IDX_W   = $clog2(N_TIMERS),
    localparam int AW      = IDX_W + 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_en,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [AW-1:0]       bus_addr,
    input  logic [WIDTH-1:0]    bus_wdata,
    output logic [WIDTH-1:0]    bus_rdata,
    output logic [N_TIMERS-1:0] irq_o
);
    logic [N_TIMERS-1:0][WIDTH-1:0] count_w;
    logic [N_TIMERS-1:0][WIDTH-1:0] reload_w;
    tmr_ctrl_t [N_TIMERS-1:0]       ctrl_w;
    logic [N_TIMERS-1:0]            load_w;
    logic [N_TIMERS-1:0]            step_w;
    logic [N_TIMERS-1:0]            expire_w;

    dtimer_regs #(
        .N(N_TIMERS), .WIDTH(WIDTH), .IDX_W(IDX_W), .AW(AW)
    ) i_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .count_i(count_w), .bus_rdata(bus_rdata),
        .reload_o(reload_w), .ctrl_o(ctrl_w), .load_o(load_w)
    );

    for (genvar k = 0; k < N_TIMERS; k++) begin : g_tmr
        if (k == 0) begin : g_base
            assign step_w[k] = tick_en;
        end else begin : g_chained
            assign step_w[k] = ctrl_w[k].chain ? expire_w[k-1] : tick_en;

            AST_CHAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
                (ctrl_w[k].chain && !load_w[k] && !expire_w[k-1]) |=> $stable(count_w[k])); // R8
        end

        dtimer_core #(.WIDTH(WIDTH)) i_core (
            .clk(clk), .rst_n(rst_n),
            .load_i(load_w[k]), .run_i(ctrl_w[k].run), .auto_i(ctrl_w[k].auto_rl),
            .step_i(step_w[k]), .reload_i(reload_w[k]),
            .count_o(count_w[k]), .irq_o(irq_o[k]), .expire_o(expire_w[k])
        );
    end
endmodule

// File: tb/test_dual_down_timer.sv
module test_dual_down_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq_o;

    int checks = 0;
    int errors = 0;
    int tick_mode = 0;
    int cyc = 0;
    int last_rise [2] = '{0, 0};
    int period [2] = '{0, 0};
    logic [1:0] irq_prev = '0;

    logic [31:0] m_cnt [2];
    logic [31:0] m_rl [2];
    bit m_irq [2], m_run [2], m_auto [2], m_chain [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_down_timer i_dual_down_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // tick generator: mode 0 always, 1 every third cycle, 2 never
    int tdiv = 0;
    always @(posedge clk) begin
        #1;
        tdiv = (tdiv + 1) % 3;
        tick_en = (tick_mode == 0) || (tick_mode == 1 && tdiv == 0);
    end

    // behavioural reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 2; k++) begin
                m_cnt[k] = 0; m_rl[k] = 0; m_irq[k] = 0;
                m_run[k] = 0; m_auto[k] = 0; m_chain[k] = 0;
            end
        end else begin
            bit exp0, st, ld;
            exp0 = m_run[0] && tick_en && m_cnt[0] == 0;
            for (int k = 0; k < 2; k++) begin
                st = (k == 1 && m_chain[1]) ? exp0 : tick_en;
                ld = bus_sel && bus_wr && bus_addr[2] == k[0] && bus_addr[1:0] == 2'd1 && bus_wdata[2];
                if (ld) begin
                    m_cnt[k] = m_rl[k]; m_irq[k] = 0;
                end else if (m_run[k] && st) begin
                    if (m_cnt[k] == 0) begin
                        if (m_auto[k]) begin m_cnt[k] = m_rl[k]; m_irq[k] = 0; end
                    end else begin
                        m_cnt[k] = m_cnt[k] - 1;
                        if (m_cnt[k] == 0) m_irq[k] = 1;
                    end
                end
            end
            if (bus_sel && bus_wr) begin
                int t;
                t = int'(bus_addr[2]);
                if (bus_addr[1:0] == 2'd0) m_rl[t] = bus_wdata;
                if (bus_addr[1:0] == 2'd1) begin
                    m_run[t] = bus_wdata[0]; m_auto[t] = bus_wdata[1];
                    m_chain[t] = (t == 1) && bus_wdata[3];
                end
            end
        end
    end

    function automatic logic [31:0] model_read();
        int t;
        t = int'(bus_addr[2]);
        case (bus_addr[1:0])
            2'd0: return m_rl[t];
            2'd1: return {28'd0, m_chain[t], 1'b0, m_auto[t], m_run[t]};
            2'd2: return m_cnt[t];
            default: return 32'd0;
        endcase
    endfunction

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            for (int k = 0; k < 2; k++) begin
                chk(irq_o[k] === m_irq[k], "R4 irq vs model", 32'(irq_o[k]), 32'(m_irq[k]));
                if (irq_o[k] && !irq_prev[k]) begin
                    period[k] = cyc - last_rise[k];
                    last_rise[k] = cyc;
                end
            end
            chk(bus_rdata === model_read(), "R1 readback vs model", bus_rdata, model_read());
        end
        irq_prev = irq_o;
    end

    task automatic bus_write(input int t, input int r, input logic [31:0] d);
        @(posedge clk); #2;
        bus_sel = 1; bus_wr = 1; bus_addr = {t[0], r[1:0]}; bus_wdata = d;
        @(posedge clk); #2;
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bus_read(input int t, input int r, output logic [31:0] v);
        @(posedge clk); #2;
        bus_sel = 1; bus_wr = 0; bus_addr = {t[0], r[1:0]};
        @(negedge clk);
        v = bus_rdata;
        @(posedge clk); #2;
        bus_sel = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++; errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        logic [31:0] v, a, b;
        idle(3);
        #2 rst_n = 1;
        // R10 reset state
        for (int t = 0; t < 2; t++) begin
            for (int r = 0; r < 4; r++) begin
                bus_read(t, r, v);
                chk(v == 0, "R10 register after reset", v, 0);
            end
        end
        chk(irq_o == 2'b00, "R10 irq after reset", 32'(irq_o), 0);

        // R5 auto-reload period with continuous ticks
        tick_mode = 0;
        bus_write(0, 0, 32'd5);
        bus_write(0, 1, 32'b0111);
        idle(30);
        chk(period[0] == 6, "R5 auto-reload period", period[0], 6);

        // R1 sparse ticks: one tick in three cycles
        tick_mode = 1;
        idle(60);
        chk(period[0] == 18, "R1 period with sparse ticks", period[0], 18);

        // R2 stopped timer holds
        tick_mode = 0;
        bus_write(0, 1, 32'b0010);
        bus_read(0, 2, a);
        idle(10);
        bus_read(0, 2, b);
        chk(a == b, "R2 count held while stopped", b, a);

        // R6 one-shot: stays at zero, irq held until load
        bus_write(0, 0, 32'd3);
        bus_write(0, 1, 32'b0101);
        idle(20);
        chk(irq_o[0] == 1'b1, "R6 irq held at zero", 32'(irq_o[0]), 1);
        bus_read(0, 2, v);
        chk(v == 0, "R6 count parked at zero", v, 0);
        bus_write(0, 1, 32'b0100);
        chk(irq_o[0] == 1'b0, "R6 load clears irq", 32'(irq_o[0]), 0);
        bus_read(0, 2, v);
        chk(v == 3, "R3 load while stopped", v, 3);

        // R3 / R9 reload write and count write do not touch the count
        bus_write(0, 0, 32'd9);
        bus_read(0, 2, v);
        chk(v == 3, "R3 reload write leaves count", v, 3);
        bus_write(0, 2, 32'h55);
        bus_read(0, 2, v);
        chk(v == 3, "R9 count register ignores writes", v, 3);
        bus_read(0, 0, v);
        chk(v == 9, "R9 reload readback", v, 9);
        bus_write(0, 1, 32'b1111);
        bus_read(0, 1, v);
        chk(v == 32'b0011, "R8 chain bit ignored on timer 0", v, 32'b0011);

        // R7 reads during counting change nothing (model compares each cycle)
        for (int i = 0; i < 40; i++) begin
            @(posedge clk); #2;
            bus_sel = 1; bus_wr = 0; bus_addr = 3'(i % 8);
        end
        @(posedge clk); #2 bus_sel = 0;
        chk(period[0] == 10, "R7 period unaffected by reads", period[0], 10);

        // R8 chained operation
        bus_write(0, 1, 32'b0000);
        bus_write(0, 0, 32'd3);
        bus_write(1, 0, 32'd2);
        bus_write(1, 1, 32'b1111);
        bus_write(0, 1, 32'b0111);
        idle(60);
        chk(period[1] == 12, "R8 chained period", period[1], 12);
        bus_read(1, 1, v);
        chk(v == 32'b1011, "R8 chain bit readback", v, 32'b1011);
        tick_mode = 1;
        idle(120);
        chk(period[1] == 36, "R8 chained period with sparse ticks", period[1], 36);

        finish_run();
    end
endmodule